// File: doc/BRIEF.md
# Ready-Slack Overflow Detector

This block watches the write side of a transmit buffer that applies back-pressure through a ready signal. The writer does not have to stop on the cycle that ready drops. It has a fixed allowance of further write cycles, and the block counts those writes. If the writer goes past the allowance while ready is still low, the block raises a sticky overflow flag. It does not block the write. When ready comes back, the allowance is restored.

A write cycle is any cycle in which the lane-0 enable (`writeEn`) is high. The ready signal can come from outside on `readyIn`. As a build-time option, the block can instead generate ready itself from a buffer fill level. In that mode ready drops when free space falls to the allowance plus a margin, and it returns only when free space has climbed a hysteresis step above that point.

Top module: `slackOvfDetect`

## Requirements
- R1: After reset `overflow` is 0 and `slackCount` is 0. In external mode (USE_FILL=0), `readyOut` equals `readyIn`. In fill mode (USE_FILL=1), `readyOut` is 1 after reset.
- R2: Any clock edge sampled with `readyOut` high leaves `slackCount` at 0. Writes made while ready is high never set `overflow`.
- R3: Each edge sampled with `readyOut` low and `writeEn` high raises `slackCount` by one, up to SLACK_MAX (default 8). These first SLACK_MAX writes do not set `overflow`.
- R4: An edge sampled with `readyOut` low and `writeEn` low leaves `slackCount` unchanged.
- R5: A write with `readyOut` low while `slackCount` equals SLACK_MAX sets `overflow` at that edge. `slackCount` saturates at SLACK_MAX and does not wrap.
- R6: Once set, `overflow` stays at 1 until reset, even after ready returns. It rises only on a violating write.
- R7: After ready returns for at least one cycle and falls again, a full new allowance of SLACK_MAX writes is accepted without overflow.
- R8: In fill mode, free space is DEPTH minus `fillLevel`. `readyOut` falls at the edge that samples free space at or below SLACK_MAX+MARGIN (default 10). It rises again at the edge that samples free space at or above SLACK_MAX+MARGIN+HYST (default 18). Between the two points it holds its value.
- R9: In fill mode, `readyIn` has no effect on `readyOut` or on `slackCount`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| readyIn | input | 1 | External ready, used when USE_FILL=0 |
| writeEn | input | 1 | Lane-0 enable; high marks a write cycle |
| fillLevel | input | $clog2(DEPTH+1) | Buffer occupancy in write cycles, used when USE_FILL=1 |
| readyOut | output | 1 | Effective ready seen by the writer |
| overflow | output | 1 | Sticky back-pressure violation flag |
| slackCount | output | $clog2(SLACK_MAX+1) | Writes made since ready fell |

## Verification
A wrong count shows up at the next clock edge on `slackCount`, which is a port. A count that lags or leads by one also moves the overflow point by a whole write cycle: a lagging count lets a ninth write through without a flag, and a leading count flags the eighth write. A failure to clear on ready return shows up the first time ready falls again, as an early overflow. The hysteresis register in fill mode is checked at both threshold edges and one step inside each, so an off-by-one compare shows up as a ready change one fill step too early or too late.

// File: rtl/slackPkg.sv
package slackPkg;

  // Strobes from control to datapath; at most one is high per cycle.
  typedef struct packed {
    logic clear;  // ready high: budget restored
    logic inc;    // write inside the allowance
    logic flag;   // write beyond the allowance
  } slackStrobeT;

endpackage

// File: rtl/slackReadyGen.sv
module slackReadyGen #(
  parameter int SLACK_MAX = 8,
  parameter bit USE_FILL  = 1'b0,
  parameter int DEPTH     = 64,
  parameter int MARGIN    = 2,
  parameter int HYST      = 8,
  localparam int FILL_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              readyIn,
  input  logic [FILL_W-1:0] fillLevel,
  output logic              readyOut
);

  localparam int STOP_FREE   = SLACK_MAX + MARGIN;
  localparam int RESUME_FREE = STOP_FREE + HYST;

  generate
    if (USE_FILL) begin : g_fill
      localparam logic [FILL_W-1:0] STOP_V   = FILL_W'(STOP_FREE);
      localparam logic [FILL_W-1:0] RESUME_V = FILL_W'(RESUME_FREE);
      logic [FILL_W-1:0] freeSpace;
      logic              rdyQ;
      logic              unusedReady;

      assign unusedReady = readyIn;
      assign freeSpace   = FILL_W'(DEPTH) - fillLevel;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          rdyQ <= 1'b1;
        end else if (rdyQ && (freeSpace <= STOP_V)) begin
          rdyQ <= 1'b0;
        end else if (!rdyQ && (freeSpace >= RESUME_V)) begin
          rdyQ <= 1'b1;
        end
      end

      assign readyOut = rdyQ;
    end else begin : g_ext
      logic unusedFill;
      assign unusedFill = ^{fillLevel, clk, rstN};
      assign readyOut   = readyIn;
    end
  endgenerate

endmodule

// File: rtl/slackCtrl.sv
module slackCtrl
  import slackPkg::*;
(
  input  logic        readyOut,
  input  logic        writeEn,
  input  logic        cntAtMax,
  output slackStrobeT strobes
);

  logic lateWrite;

  assign lateWrite = !readyOut && writeEn;

  always_comb begin
    strobes       = '0;
    strobes.clear = readyOut;
    strobes.inc   = lateWrite && !cntAtMax;
    strobes.flag  = lateWrite && cntAtMax;
  end

endmodule

// File: rtl/slackDatapath.sv
module slackDatapath
  import slackPkg::*;
#(
  parameter int SLACK_MAX = 8,
  localparam int CNT_W    = $clog2(SLACK_MAX + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  slackStrobeT      strobes,
  output logic             cntAtMax,
  output logic [CNT_W-1:0] slackCount,
  output logic             overflow
);

  localparam logic [CNT_W-1:0] MAX_V = CNT_W'(SLACK_MAX);

  logic [CNT_W-1:0] cntQ;
  logic             ovfQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strobes.clear) begin
      cntQ <= '0;
    end else if (strobes.inc) begin
      cntQ <= cntQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovfQ <= 1'b0;
    end else if (strobes.flag) begin
      ovfQ <= 1'b1;
    end
  end

  assign cntAtMax   = (cntQ == MAX_V);
  assign slackCount = cntQ;
  assign overflow   = ovfQ;

endmodule

// File: rtl/slackOvfDetect.sv
module slackOvfDetect
  import slackPkg::*;
#(
  parameter int SLACK_MAX = 8,
  parameter bit USE_FILL  = 1'b0,
  parameter int DEPTH     = 64,
  parameter int MARGIN    = 2,
  parameter int HYST      = 8,
  localparam int FILL_W   = $clog2(DEPTH + 1),
  localparam int CNT_W    = $clog2(SLACK_MAX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              readyIn,
  input  logic              writeEn,
  input  logic [FILL_W-1:0] fillLevel,
  output logic              readyOut,
  output logic              overflow,
  output logic [CNT_W-1:0]  slackCount
);

  slackStrobeT strobes;
  logic        cntAtMax;

  slackReadyGen #(
    .SLACK_MAX(SLACK_MAX), .USE_FILL(USE_FILL), .DEPTH(DEPTH),
    .MARGIN(MARGIN), .HYST(HYST)
  ) u_readyGen (
    .clk(clk), .rstN(rstN), .readyIn(readyIn),
    .fillLevel(fillLevel), .readyOut(readyOut)
  );

  slackCtrl u_ctrl (
    .readyOut(readyOut), .writeEn(writeEn),
    .cntAtMax(cntAtMax), .strobes(strobes)
  );

  slackDatapath #(.SLACK_MAX(SLACK_MAX)) u_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .cntAtMax(cntAtMax), .slackCount(slackCount), .overflow(overflow)
  );

endmodule

// File: rtl/slackOvfChecker.sv
module slackOvfChecker #(
  parameter int SLACK_MAX = 8,
  localparam int CNT_W    = $clog2(SLACK_MAX + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             readyOut,
  input logic             writeEn,
  input logic             overflow,
  input logic [CNT_W-1:0] slackCount
);

  localparam logic [CNT_W-1:0] MAX_V = CNT_W'(SLACK_MAX);

  // R2
  ready_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    readyOut |=> (slackCount == '0));

  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    slackCount <= MAX_V);

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!readyOut && writeEn && slackCount != MAX_V) |=> (slackCount == $past(slackCount) + 1'b1));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!readyOut && !writeEn) |=> $stable(slackCount));

  // R5
  violation_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!readyOut && writeEn && slackCount == MAX_V) |=> (overflow && slackCount == MAX_V));

  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  // R6
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> $past(!readyOut && writeEn && slackCount == MAX_V));

endmodule

bind slackOvfDetect slackOvfChecker #(.SLACK_MAX(SLACK_MAX)) u_slackChk (
  .clk(clk), .rstN(rstN), .readyOut(readyOut), .writeEn(writeEn),
  .overflow(overflow), .slackCount(slackCount)
);

// File: tb/test_slackOvfDetect.sv
module test_slackOvfDetect;

  localparam int FW = 7;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rstN;
  logic          readyIn, writeEn;
  logic          fReadyIn, fWriteEn;
  logic [FW-1:0] fillLevel, fFill;
  logic          readyOut, overflow, fReadyOut, fOverflow;
  logic [CW-1:0] slackCount, fCount;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  slackOvfDetect i_slackOvfDetect (
    .clk(clk), .rstN(rstN), .readyIn(readyIn), .writeEn(writeEn),
    .fillLevel(fillLevel), .readyOut(readyOut), .overflow(overflow),
    .slackCount(slackCount)
  );

  slackOvfDetect #(.USE_FILL(1'b1)) i_slackOvfDetectFill (
    .clk(clk), .rstN(rstN), .readyIn(fReadyIn), .writeEn(fWriteEn),
    .fillLevel(fFill), .readyOut(fReadyOut), .overflow(fOverflow),
    .slackCount(fCount)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Inputs change at negedge; one posedge; outputs read at following negedge.
  task automatic step(input logic r, input logic w);
    readyIn = r;
    writeEn = w;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0; readyIn = 1'b1; writeEn = 1'b0; fillLevel = '0;
    fReadyIn = 1'b1; fWriteEn = 1'b0; fFill = '0;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic testReset();
    doReset();
    chk("R1 overflow", overflow, 0);
    chk("R1 count", slackCount, 0);
    readyIn = 1'b0; #1;
    chk("R1 readyOut follows readyIn", readyOut, 0);
    chk("R1 fill readyOut", fReadyOut, 1);
    readyIn = 1'b1;
  endtask

  task automatic testReadyHigh();
    for (int i = 0; i < 20; i++) step(1'b1, 1'b1);
    chk("R2 count while ready", slackCount, 0);
    chk("R2 no overflow while ready", overflow, 0);
  endtask

  task automatic testAllowance();
    for (int i = 1; i <= 8; i++) begin
      step(1'b0, 1'b1);
      chk("R3 count step", slackCount, i);
      step(1'b0, 1'b0);
      chk("R4 idle hold", slackCount, i);
    end
    chk("R3 eight writes no overflow", overflow, 0);
    step(1'b1, 1'b0);
    chk("R2 clear on ready", slackCount, 0);
  endtask

  task automatic testViolation();
    for (int i = 0; i < 8; i++) step(1'b0, 1'b1);
    chk("R7 fresh allowance count", slackCount, 8);
    chk("R7 fresh allowance no overflow", overflow, 0);
    step(1'b0, 1'b1);
    chk("R5 ninth write flags", overflow, 1);
    chk("R5 count saturates", slackCount, 8);
    step(1'b0, 1'b1);
    chk("R5 count still saturated", slackCount, 8);
    step(1'b1, 1'b0);
    chk("R6 overflow sticky", overflow, 1);
    chk("R2 count cleared after return", slackCount, 0);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1);
    chk("R6 overflow still set", overflow, 1);
    doReset();
    chk("R1 reset clears overflow", overflow, 0);
  endtask

  task automatic fillStep(input int fill);
    fFill = FW'(fill);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic testFill();
    doReset();
    fillStep(53);
    chk("R8 free 11 keeps ready", fReadyOut, 1);
    fillStep(54);
    chk("R8 free 10 drops ready", fReadyOut, 0);
    fillStep(47);
    chk("R8 free 17 holds low", fReadyOut, 0);
    fWriteEn = 1'b1;
    fillStep(47);
    fWriteEn = 1'b0;
    chk("R8 late write counted", fCount, 1);
    fillStep(46);
    chk("R8 free 18 restores ready", fReadyOut, 1);
    fillStep(50);
    chk("R8 free 14 holds high", fReadyOut, 1);
    fReadyIn = 1'b0; fWriteEn = 1'b1;
    for (int i = 0; i < 12; i++) fillStep(20);
    chk("R9 readyIn ignored ready", fReadyOut, 1);
    chk("R9 readyIn ignored count", fCount, 0);
    chk("R9 readyIn ignored overflow", fOverflow, 0);
    fWriteEn = 1'b0; fReadyIn = 1'b1;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    testReset();
    testReadyHigh();
    testAllowance();
    testViolation();
    testFill();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule